// File: doc/BRIEF.md
# Shadow-Register Frequency-Change Sequencer

This block keeps a software-visible shadow copy of a clock configuration (a primary and a secondary post-divider value, a PLL operating mode, two divide-by-1/divide-by-2 interconnect clock selects and a DLL override bit) next to the live copy that drives the clock tree. Software fills the shadow words at its own pace. It then sets an update bit to start a hardware sequence that moves the whole configuration across in one cycle, at a moment when no memory traffic can be disturbed.

The sequence raises an idle request to the external memory controller. If software has enabled it, the sequence also raises one to a secondary general-purpose memory controller. It waits for every acknowledge it asked for, and it can hold a DLL in reset for a fixed number of cycles. It then loads the live registers, drops the idle requests and clears the update bit. Fields that belong to the secondary controller are applied only when that controller took part in the handshake. While the live override bit is set, the DLL lock and code seen downstream are replaced by a forced lock and an externally supplied code.

Top module: `fcs_freq_seq`

## Requirements
- R1: After reset the live primary and secondary dividers read 1, the PLL mode reads 7, both clock selects and the override read 0, and updatePending, busy, memIdleReq, gpIdleReq and dllReset are 0.
- R2: A write to word 0 with bit 15 set raises updatePending on that clock edge; memIdleReq rises on the following edge.
- R3: No live field changes unless memIdleAck is high; memIdleReq stays high while it waits for memIdleAck and drops on the edge that loads the live fields.
- R4: With the secondary enable (word 1 bit 7) set, gpIdleReq is raised together with memIdleReq, the load waits for gpIdleAck as well, and the secondary divider and both selects are loaded.
- R5: With the secondary enable clear, gpIdleReq stays 0 and the live secondary divider and selects keep their values.
- R6: With the DLL-reset option (word 0 bit 8) set, dllReset is high for exactly DLL_RST_CYCLES cycles while the idle requests are held, before the load; with it clear, dllReset never rises.
- R7: When the live override (loaded from word 0 bit 9) is 1, dllLockOut is 1 and dllCodeOut equals ovrCodeIn; when it is 0 they follow dllLockIn and dllCodeIn.
- R8: updatePending falls exactly once per sequence, two clock edges after the edge on which memIdleReq drops.
- R9: Writes to either shadow word while busy is high have no effect on any later load.
- R10: A write to word 0 with bit 15 clear updates the shadow fields but starts no sequence. Word 0 holds the primary divider in bits 4:0 and the PLL mode in bits 7:5. Word 1 holds the secondary divider in bits 4:0, the L3 select in bit 5 and the core select in bit 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Shadow write strobe |
| wrAddr | input | 1 | Shadow word select (0 primary, 1 secondary) |
| wrData | input | 16 | Shadow write data |
| memIdleAck | input | 1 | External memory controller idle acknowledge |
| gpIdleAck | input | 1 | Secondary memory controller idle acknowledge |
| dllLockIn | input | 1 | Lock indication from the DLL |
| dllCodeIn | input | CODE_W | Delay code from the DLL |
| ovrCodeIn | input | CODE_W | Substitute delay code used under override |
| updatePending | output | 1 | Update request bit |
| busy | output | 1 | Sequence in progress |
| memIdleReq | output | 1 | Idle request to external memory controller |
| gpIdleReq | output | 1 | Idle request to secondary memory controller |
| dllReset | output | 1 | DLL reset pulse |
| dllLockOut | output | 1 | Lock after override |
| dllCodeOut | output | CODE_W | Code after override |
| primDiv | output | 5 | Live primary divider |
| pllMode | output | 3 | Live PLL mode |
| secDiv | output | 5 | Live secondary divider |
| selL3 | output | 1 | Live L3 divide-by-2 select |
| selCore | output | 1 | Live core divide-by-2 select |

## Verification
updatePending is due at the first falling edge after the write edge, and memIdleReq one cycle later. The bench samples both there. Acknowledge latency is random, so the load edge is not fixed in time. The bench records at every falling edge whether a live field changed without its acknowledge, and it timestamps the fall of memIdleReq and of updatePending to confirm the two-edge gap. Live fields, DLL pulse length and override outputs are compared two cycles after updatePending falls, once the handshake has settled.

// File: rtl/fcs_pkg.sv
package fcs_pkg;
  localparam int DIV_W  = 5;
  localparam int MODE_W = 3;
  localparam int DATA_W = 16;

  localparam int W0_MODE_LSB = DIV_W;
  localparam int W0_DLLRST   = DIV_W + MODE_W;
  localparam int W0_OVR      = W0_DLLRST + 1;
  localparam int W0_UPD      = DATA_W - 1;
  localparam int W1_SELL3    = DIV_W;
  localparam int W1_SELCORE  = DIV_W + 1;
  localparam int W1_GPEN     = DIV_W + 2;

  localparam logic [DIV_W-1:0]  RST_DIV  = DIV_W'(1);
  localparam logic [MODE_W-1:0] RST_MODE = '1;

  typedef enum logic [2:0] {
    ST_IDLE, ST_REQ_IDLE, ST_WAIT_ACK, ST_DLL_RST, ST_LOAD, ST_RELEASE, ST_DONE
  } seqState_t;

  typedef struct packed {
    logic busy;
    logic reqMem;
    logic reqGp;
    logic dllRst;
    logic loadPrim;
    logic loadSec;
    logic clearUpd;
  } seqStrobe_t;

  typedef struct packed {
    logic updReq;
    logic gpEn;
    logic dllRstOpt;
  } shadowStat_t;

  typedef struct packed {
    logic [DIV_W-1:0]  div;
    logic [MODE_W-1:0] mode;
    logic              ovr;
  } primCfg_t;

  typedef struct packed {
    logic [DIV_W-1:0] div;
    logic             selL3;
    logic             selCore;
  } secCfg_t;
endpackage

// File: rtl/fcs_seq_ctrl.sv
module fcs_seq_ctrl
  import fcs_pkg::*;
#(
  parameter int DLL_RST_CYCLES = 4
) (
  input  logic        clk,
  input  logic        rstN,
  input  shadowStat_t stat,
  input  logic        memIdleAck,
  input  logic        gpIdleAck,
  output seqStrobe_t  strobe
);
  localparam int CNT_W = $clog2(DLL_RST_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DLL_RST_CYCLES - 1);

  seqState_t stateQ, stateD;
  logic [CNT_W-1:0] rstCnt;
  logic acksDone;
  logic holdIdle;

  assign acksDone = memIdleAck && (!stat.gpEn || gpIdleAck);

  always_comb begin
    stateD = stateQ;
    unique case (stateQ)
      ST_IDLE:     if (stat.updReq) stateD = ST_REQ_IDLE;
      ST_REQ_IDLE: stateD = ST_WAIT_ACK;
      ST_WAIT_ACK: if (acksDone) stateD = stat.dllRstOpt ? ST_DLL_RST : ST_LOAD;
      ST_DLL_RST:  if (rstCnt == CNT_LAST) stateD = ST_LOAD;
      ST_LOAD:     stateD = ST_RELEASE;
      ST_RELEASE:  stateD = ST_DONE;
      ST_DONE:     stateD = ST_IDLE;
      default:     stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ <= ST_IDLE;
      rstCnt <= '0;
    end else begin
      stateQ <= stateD;
      if (stateQ == ST_DLL_RST) rstCnt <= rstCnt + CNT_W'(1);
      else                      rstCnt <= '0;
    end
  end

  assign holdIdle = (stateQ == ST_REQ_IDLE) || (stateQ == ST_WAIT_ACK) ||
                    (stateQ == ST_DLL_RST)  || (stateQ == ST_LOAD);

  always_comb begin
    strobe          = '0;
    strobe.busy     = (stateQ != ST_IDLE);
    strobe.reqMem   = holdIdle;
    strobe.reqGp    = holdIdle && stat.gpEn;
    strobe.dllRst   = (stateQ == ST_DLL_RST);
    strobe.loadPrim = (stateQ == ST_LOAD);
    strobe.loadSec  = (stateQ == ST_LOAD) && stat.gpEn;
    strobe.clearUpd = (stateQ == ST_DONE);
  end
endmodule

// File: rtl/fcs_shadow_dp.sv
module fcs_shadow_dp
  import fcs_pkg::*;
#(
  parameter int CODE_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  seqStrobe_t        strobe,
  input  logic              dllLockIn,
  input  logic [CODE_W-1:0] dllCodeIn,
  input  logic [CODE_W-1:0] ovrCodeIn,
  output shadowStat_t       stat,
  output primCfg_t          livePrim,
  output secCfg_t           liveSec,
  output logic              dllLockOut,
  output logic [CODE_W-1:0] dllCodeOut
);
  primCfg_t shPrim;
  secCfg_t  shSec;
  logic     shUpd, shGpEn, shDllRstOpt;
  logic     wrPrim, wrSec;

  assign wrPrim = wrEn && !strobe.busy && (wrAddr == 1'b0);
  assign wrSec  = wrEn && !strobe.busy && (wrAddr == 1'b1);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shPrim      <= '{div: RST_DIV, mode: RST_MODE, ovr: 1'b0};
      shSec       <= '{div: RST_DIV, selL3: 1'b0, selCore: 1'b0};
      shUpd       <= 1'b0;
      shGpEn      <= 1'b0;
      shDllRstOpt <= 1'b0;
    end else begin
      if (wrPrim) begin
        shPrim.div  <= wrData[DIV_W-1:0];
        shPrim.mode <= wrData[W0_MODE_LSB +: MODE_W];
        shPrim.ovr  <= wrData[W0_OVR];
        shDllRstOpt <= wrData[W0_DLLRST];
        shUpd       <= shUpd | wrData[W0_UPD];
      end else if (strobe.clearUpd) begin
        shUpd <= 1'b0;
      end
      if (wrSec) begin
        shSec.div     <= wrData[DIV_W-1:0];
        shSec.selL3   <= wrData[W1_SELL3];
        shSec.selCore <= wrData[W1_SELCORE];
        shGpEn        <= wrData[W1_GPEN];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      livePrim <= '{div: RST_DIV, mode: RST_MODE, ovr: 1'b0};
      liveSec  <= '{div: RST_DIV, selL3: 1'b0, selCore: 1'b0};
    end else begin
      if (strobe.loadPrim) livePrim <= shPrim;
      if (strobe.loadSec)  liveSec  <= shSec;
    end
  end

  assign stat       = '{updReq: shUpd, gpEn: shGpEn, dllRstOpt: shDllRstOpt};
  assign dllLockOut = livePrim.ovr ? 1'b1 : dllLockIn;
  assign dllCodeOut = livePrim.ovr ? ovrCodeIn : dllCodeIn;
endmodule

// File: rtl/fcs_freq_seq.sv
module fcs_freq_seq
  import fcs_pkg::*;
#(
  parameter int CODE_W         = 8,
  parameter int DLL_RST_CYCLES = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              wrAddr,
  input  logic [15:0]       wrData,
  input  logic              memIdleAck,
  input  logic              gpIdleAck,
  input  logic              dllLockIn,
  input  logic [CODE_W-1:0] dllCodeIn,
  input  logic [CODE_W-1:0] ovrCodeIn,
  output logic              updatePending,
  output logic              busy,
  output logic              memIdleReq,
  output logic              gpIdleReq,
  output logic              dllReset,
  output logic              dllLockOut,
  output logic [CODE_W-1:0] dllCodeOut,
  output logic [4:0]        primDiv,
  output logic [2:0]        pllMode,
  output logic [4:0]        secDiv,
  output logic              selL3,
  output logic              selCore
);
  seqStrobe_t  strobe;
  shadowStat_t stat;
  primCfg_t    livePrim;
  secCfg_t     liveSec;

  fcs_seq_ctrl #(.DLL_RST_CYCLES(DLL_RST_CYCLES)) uCtrl (
    .clk(clk), .rstN(rstN), .stat(stat),
    .memIdleAck(memIdleAck), .gpIdleAck(gpIdleAck), .strobe(strobe)
  );

  fcs_shadow_dp #(.CODE_W(CODE_W)) uDp (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .strobe(strobe), .dllLockIn(dllLockIn), .dllCodeIn(dllCodeIn),
    .ovrCodeIn(ovrCodeIn), .stat(stat), .livePrim(livePrim), .liveSec(liveSec),
    .dllLockOut(dllLockOut), .dllCodeOut(dllCodeOut)
  );

  assign updatePending = stat.updReq;
  assign busy          = strobe.busy;
  assign memIdleReq    = strobe.reqMem;
  assign gpIdleReq     = strobe.reqGp;
  assign dllReset      = strobe.dllRst;
  assign primDiv       = livePrim.div;
  assign pllMode       = livePrim.mode;
  assign secDiv        = liveSec.div;
  assign selL3         = liveSec.selL3;
  assign selCore       = liveSec.selCore;
endmodule

// File: rtl/fcs_freq_seq_chk.sv
module fcs_freq_seq_chk #(
  parameter int CODE_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              updatePending,
  input logic              busy,
  input logic              memIdleReq,
  input logic              memIdleAck,
  input logic              gpIdleReq,
  input logic              gpIdleAck,
  input logic              dllReset,
  input logic              dllLockOut,
  input logic [CODE_W-1:0] dllCodeIn,
  input logic [CODE_W-1:0] dllCodeOut,
  input logic [4:0]        primDiv,
  input logic [2:0]        pllMode,
  input logic [4:0]        secDiv,
  input logic              selL3,
  input logic              selCore
);
  AST_PRIM_AFTER_ACK: assert property (@(posedge clk) disable iff (!rstN)
    !$stable({primDiv, pllMode}) |-> $past(memIdleReq && memIdleAck)); // R3
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (memIdleReq && !memIdleAck) |=> memIdleReq); // R3
  AST_SEC_AFTER_GP: assert property (@(posedge clk) disable iff (!rstN)
    !$stable({secDiv, selL3, selCore}) |-> $past(gpIdleReq && gpIdleAck)); // R5
  AST_GP_WITH_MEM: assert property (@(posedge clk) disable iff (!rstN)
    gpIdleReq |-> memIdleReq); // R4
  AST_DLLRST_IN_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    dllReset |-> (memIdleReq && busy)); // R6
  AST_OVR_FORCES_LOCK: assert property (@(posedge clk) disable iff (!rstN)
    (dllCodeOut != dllCodeIn) |-> dllLockOut); // R7
  AST_CLEAR_ENDS_SEQ: assert property (@(posedge clk) disable iff (!rstN)
    $fell(updatePending) |-> (!busy && !memIdleReq && $past(busy))); // R8
endmodule

bind fcs_freq_seq fcs_freq_seq_chk #(.CODE_W(CODE_W)) uChk (
  .clk(clk), .rstN(rstN), .updatePending(updatePending), .busy(busy),
  .memIdleReq(memIdleReq), .memIdleAck(memIdleAck), .gpIdleReq(gpIdleReq),
  .gpIdleAck(gpIdleAck), .dllReset(dllReset), .dllLockOut(dllLockOut),
  .dllCodeIn(dllCodeIn), .dllCodeOut(dllCodeOut), .primDiv(primDiv),
  .pllMode(pllMode), .secDiv(secDiv), .selL3(selL3), .selCore(selCore)
);

// File: tb/fcs_freq_seq_test.sv
module fcs_freq_seq_test;
  localparam int CODE_W = 8;
  localparam int DLL_RST_CYCLES = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0, wrAddr = 1'b0;
  logic [15:0] wrData = '0;
  logic memIdleAck = 1'b0, gpIdleAck = 1'b0, dllLockIn = 1'b0;
  logic [CODE_W-1:0] dllCodeIn = '0, ovrCodeIn = '0;
  logic updatePending, busy, memIdleReq, gpIdleReq, dllReset, dllLockOut;
  logic [CODE_W-1:0] dllCodeOut;
  logic [4:0] primDiv, secDiv;
  logic [2:0] pllMode;
  logic selL3, selCore;

  fcs_freq_seq #(.CODE_W(CODE_W), .DLL_RST_CYCLES(DLL_RST_CYCLES)) uut (.*);

  always #5 clk = ~clk;

  int checks = 0, failures = 0, cyc = 0;
  int clears, dllCnt, reqFallCyc, pendFallCyc;
  bit gpSeen, violPrim, violSec, prevPend, prevReq;
  logic [7:0] prevPrim, prevSec;
  int memCnt, gpCnt;
  bit memArmed, gpArmed;

  // bench model of shadow and live state
  logic [4:0] mPrimDiv = 5'd1, mSecDiv = 5'd1, lPrimDiv = 5'd1, lSecDiv = 5'd1;
  logic [2:0] mMode = 3'd7, lMode = 3'd7;
  logic mOvr = 0, lOvr = 0, mL3 = 0, mCore = 0, lL3 = 0, lCore = 0, mGp = 0, mOpt = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] word0(input logic [4:0] d, input logic [2:0] m,
                                        input logic opt, input logic ovr, input logic upd);
    return {upd, 5'b0, ovr, opt, m, d};
  endfunction

  function automatic logic [15:0] word1(input logic [4:0] d, input logic l3,
                                        input logic core, input logic gp);
    return {8'b0, gp, core, l3, d};
  endfunction

  task automatic wr(input logic a, input logic [15:0] d);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  always @(negedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      failures++; checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
    if (rstN) begin
      if (prevPend && !updatePending) begin clears++; pendFallCyc = cyc; end
      if (prevReq && !memIdleReq) reqFallCyc = cyc;
      if (dllReset) dllCnt++;
      if (gpIdleReq) gpSeen = 1;
      if ({primDiv, pllMode} != prevPrim && !memIdleAck) violPrim = 1;
      if ({secDiv, selL3, selCore, 1'b0} != prevSec && !gpIdleAck) violSec = 1;
    end
    if (!memIdleReq) begin memIdleAck = 0; memArmed = 0; end
    else if (!memIdleAck) begin
      if (!memArmed) begin memCnt = int'($urandom_range(0, 10)); memArmed = 1; end
      else if (memCnt == 0) memIdleAck = 1;
      else memCnt--;
    end
    if (!gpIdleReq) begin gpIdleAck = 0; gpArmed = 0; end
    else if (!gpIdleAck) begin
      if (!gpArmed) begin gpCnt = int'($urandom_range(0, 14)); gpArmed = 1; end
      else if (gpCnt == 0) gpIdleAck = 1;
      else gpCnt--;
    end
    prevPend = updatePending; prevReq = memIdleReq;
    prevPrim = {primDiv, pllMode}; prevSec = {secDiv, selL3, selCore, 1'b0};
  end

  task automatic runSeq(input logic [4:0] pd, input logic [2:0] md, input logic opt,
                        input logic ovr, input logic [4:0] sd, input logic l3,
                        input logic core, input logic gp, input bit busyWr);
    int wait_n;
    wr(1'b1, word1(sd, l3, core, gp));
    mSecDiv = sd; mL3 = l3; mCore = core; mGp = gp;
    clears = 0; dllCnt = 0; gpSeen = 0; violPrim = 0; violSec = 0;
    wr(1'b0, word0(pd, md, opt, ovr, 1'b1));
    mPrimDiv = pd; mMode = md; mOpt = opt; mOvr = ovr;
    chk(updatePending == 1 && memIdleReq == 0, "R2", "pending after write",
        {updatePending, memIdleReq}, 2);
    @(negedge clk);
    chk(memIdleReq == 1, "R2", "memIdleReq one cycle later", memIdleReq, 1);
    if (busyWr) begin
      // R9: shadow writes during the sequence must be dropped
      wr(1'b1, word1(~sd, ~l3, ~core, ~gp));
      wr(1'b0, word0(~pd, ~md, ~opt, ~ovr, 1'b1));
    end
    wait_n = 0;
    while (updatePending && wait_n < 2000) begin @(negedge clk); wait_n++; end
    @(negedge clk); @(negedge clk);
    lPrimDiv = mPrimDiv; lMode = mMode; lOvr = mOvr;
    if (mGp) begin lSecDiv = mSecDiv; lL3 = mL3; lCore = mCore; end
    chk(!violPrim, "R3", "primary change without ack", violPrim, 0);
    chk({primDiv, pllMode} == {lPrimDiv, lMode}, "R3", "live primary",
        {primDiv, pllMode}, {lPrimDiv, lMode});
    chk({secDiv, selL3, selCore} == {lSecDiv, lL3, lCore}, mGp ? "R4" : "R5",
        "live secondary", {secDiv, selL3, selCore}, {lSecDiv, lL3, lCore});
    chk(gpSeen == mGp, mGp ? "R4" : "R5", "gpIdleReq seen", gpSeen, mGp);
    chk(!violSec, "R4", "secondary change without gp ack", violSec, 0);
    chk(dllCnt == (mOpt ? DLL_RST_CYCLES : 0), "R6", "dllReset cycles", dllCnt,
        mOpt ? DLL_RST_CYCLES : 0);
    chk(clears == 1, "R8", "request clear count", clears, 1);
    chk(pendFallCyc - reqFallCyc == 2, "R8", "clear after release",
        pendFallCyc - reqFallCyc, 2);
    if (busyWr) chk(busy == 0, "R9", "idle after busy writes", busy, 0);
    dllLockIn = 1'b0; dllCodeIn = CODE_W'($urandom); ovrCodeIn = ~dllCodeIn;
    @(negedge clk);
    chk(dllLockOut == lOvr, "R7", "lock output", dllLockOut, lOvr);
    chk(dllCodeOut == (lOvr ? ovrCodeIn : dllCodeIn), "R7", "code output",
        dllCodeOut, lOvr ? ovrCodeIn : dllCodeIn);
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk({primDiv, pllMode, secDiv, selL3, selCore} == {5'd1, 3'd7, 5'd1, 2'b00}, "R1",
        "reset live fields", {primDiv, pllMode, secDiv, selL3, selCore},
        {5'd1, 3'd7, 5'd1, 2'b00});
    chk({updatePending, busy, memIdleReq, gpIdleReq, dllReset, dllLockOut} == 6'b0, "R1",
        "reset controls", {updatePending, busy, memIdleReq, gpIdleReq, dllReset}, 0);

    // R10: shadow write without update bit
    wr(1'b0, word0(5'd9, 3'd2, 1'b0, 1'b0, 1'b0));
    mPrimDiv = 5'd9; mMode = 3'd2;
    repeat (6) @(negedge clk);
    chk(updatePending == 0 && memIdleReq == 0, "R10", "no sequence started",
        {updatePending, memIdleReq}, 0);
    chk(primDiv == 5'd1 && pllMode == 3'd7, "R10", "live unchanged", primDiv, 1);

    // directed corners
    runSeq(5'd31, 3'd4, 1'b1, 1'b0, 5'd17, 1'b1, 1'b1, 1'b0, 1'b0);
    runSeq(5'd1, 3'd5, 1'b0, 1'b1, 5'd31, 1'b1, 1'b0, 1'b1, 1'b1);
    runSeq(5'd2, 3'd6, 1'b1, 1'b1, 5'd3, 1'b0, 1'b1, 1'b1, 1'b0);

    for (int i = 0; i < 40; i++) begin
      runSeq(5'($urandom_range(1, 31)), 3'($urandom), 1'($urandom), 1'($urandom),
             5'($urandom_range(1, 31)), 1'($urandom), 1'($urandom), 1'($urandom),
             1'($urandom));
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule